// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches two independent memory ports and decides, every clock cycle, whether the ports collide. They collide when both ports are selected and both point at the same word. When they do, one port keeps access and the other is told to wait through an active-low busy signal. The block also gates each port's write strobe, so a port that lost arbitration cannot write the shared word.

Arrival order is judged per clock. A port that held the same enabled address in the previous cycle counts as earlier than a port that has just arrived. When both arrive in the same cycle, the left port wins. Once a port has won, it keeps the word for as long as it stays on that address with its select asserted.

A mode input chooses between two roles. In master mode the block drives its busy outputs from its own decision. In slave mode it drives them inactive and takes busy from a master device instead, so that devices ganged for a wider word all follow one decision.

Top module: `dp_contention_arb`

## Requirements
- R1: Busy (active low, 0 = busy) stays high on both ports unless both selects (active low) are low and the two addresses are equal. A port with its select high never causes busy, whatever its other inputs are.
- R2: When contention starts and exactly one port held the same enabled address in the previous cycle, that port wins. The other port's busy goes low in the same cycle the contention starts.
- R3: When both ports start contending in the same cycle, the left port wins and only the right busy goes low. The two busy outputs are never low together.
- R4: The winner keeps ownership while the contention lasts with its own address and select unchanged.
- R5: Busy returns high in the same cycle the addresses stop matching or either select goes high. If the former loser is then still enabled, it counts as the earlier port in the next contention.
- R6: In master mode (mode input = 1) the busy outputs carry the block's decision, and the busy inputs have no effect.
- R7: In slave mode (mode input = 0) both busy outputs stay high. Each port's busy comes from its own busy input instead.
- R8: A port's write enable output (active high) is 1 exactly when its select is low, its read/write strobe is low (0 = write) and that port is not busy. A write from a busy port is suppressed.
- R9: Reset clears ownership and arrival history. After reset both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = master (drives busy), 0 = slave (takes busy) |
| leftCeN | input | 1 | Left port select, active low |
| leftAddr | input | ADDR_W | Left port word address |
| leftRwN | input | 1 | Left read/write strobe, 0 = write |
| rightCeN | input | 1 | Right port select, active low |
| rightAddr | input | ADDR_W | Right port word address |
| rightRwN | input | 1 | Right read/write strobe, 0 = write |
| leftBusyInN | input | 1 | Left busy from an external master, active low (slave mode) |
| rightBusyInN | input | 1 | Right busy from an external master, active low (slave mode) |
| leftBusyOutN | output | 1 | Left busy output, active low |
| rightBusyOutN | output | 1 | Right busy output, active low |
| leftWrEn | output | 1 | Gated left write enable to the array |
| rightWrEn | output | 1 | Gated right write enable to the array |

## Verification
The arbitration is tried with four arrival patterns: left first, right first, both in the same cycle, and a hand-off where the winner drops its select and then comes back. These show apart the held-address rule, the fixed tie rule and the release of ownership. Near misses check that neither condition alone raises busy: differing addresses, and one select high on an equal address. In slave mode, a busy input asserted on one side only shows that the write gating follows the external decision and not the internal one.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerE;

  // status from datapath to control
  typedef struct packed {
    logic match;
    logic leftHeld;
    logic rightHeld;
  } arbStatusT;

  // strobes from control to datapath
  typedef struct packed {
    logic leftWins;
    logic rightWins;
  } arbStrobeT;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftRwN,
  input  logic              rightCeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightRwN,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  input  arbStrobeT         strobe,
  output arbStatusT         status,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWrEn,
  output logic              rightWrEn
);
  logic              leftPrevEn, rightPrevEn;
  logic [ADDR_W-1:0] leftPrevAddr, rightPrevAddr;
  logic              leftBusyEff, rightBusyEff;

  // arrival history: enabled address seen in the previous cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftPrevEn    <= 1'b0;
      rightPrevEn   <= 1'b0;
      leftPrevAddr  <= '0;
      rightPrevAddr <= '0;
    end else begin
      leftPrevEn    <= !leftCeN;
      rightPrevEn   <= !rightCeN;
      leftPrevAddr  <= leftAddr;
      rightPrevAddr <= rightAddr;
    end
  end

  always_comb begin
    status.match     = !leftCeN && !rightCeN && (leftAddr == rightAddr);
    status.leftHeld  = !leftCeN && leftPrevEn && (leftPrevAddr == leftAddr);
    status.rightHeld = !rightCeN && rightPrevEn && (rightPrevAddr == rightAddr);
  end

  always_comb begin
    if (masterMode) begin
      leftBusyEff   = strobe.rightWins;
      rightBusyEff  = strobe.leftWins;
      leftBusyOutN  = !strobe.rightWins;
      rightBusyOutN = !strobe.leftWins;
    end else begin
      leftBusyEff   = !leftBusyInN;
      rightBusyEff  = !rightBusyInN;
      leftBusyOutN  = 1'b1;
      rightBusyOutN = 1'b1;
    end
    leftWrEn  = !leftCeN && !leftRwN && !leftBusyEff;
    rightWrEn = !rightCeN && !rightRwN && !rightBusyEff;
  end

  AST_NO_MATCH_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !status.match |-> (leftBusyOutN && rightBusyOutN)); // R1
  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(!leftBusyOutN && !rightBusyOutN)); // R3
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (leftBusyOutN && rightBusyOutN)); // R7
  AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (leftWrEn |-> (!leftCeN && !leftRwN)) and (rightWrEn |-> (!rightCeN && !rightRwN))); // R8
  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !leftBusyOutN) |-> !leftWrEn); // R8
endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  arbStatusT status,
  output arbStrobeT strobe
);
  ownerE ownerQ, ownerD;

  always_comb begin
    ownerD = OWN_NONE;
    if (status.match) begin
      if (ownerQ == OWN_LEFT && status.leftHeld)        ownerD = OWN_LEFT;
      else if (ownerQ == OWN_RIGHT && status.rightHeld) ownerD = OWN_RIGHT;
      else if (status.rightHeld && !status.leftHeld)    ownerD = OWN_RIGHT;
      else                                              ownerD = OWN_LEFT;
    end
    strobe.leftWins  = (ownerD == OWN_LEFT);
    strobe.rightWins = (ownerD == OWN_RIGHT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ownerQ <= OWN_NONE;
    else       ownerQ <= ownerD;
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.leftWins, strobe.rightWins})); // R3
  AST_WINNER_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    status.match |-> (strobe.leftWins || strobe.rightWins)); // R2
  AST_KEEP_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.leftWins ##1 (status.match && status.leftHeld) |-> strobe.leftWins); // R4
  AST_KEEP_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rightWins ##1 (status.match && status.rightHeld) |-> strobe.rightWins); // R4
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftRwN,
  input  logic              rightCeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightRwN,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWrEn,
  output logic              rightWrEn
);
  arbStatusT status;
  arbStrobeT strobe;

  arb_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftCeN(leftCeN), .leftAddr(leftAddr), .leftRwN(leftRwN),
    .rightCeN(rightCeN), .rightAddr(rightAddr), .rightRwN(rightRwN),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .strobe(strobe), .status(status),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftWrEn(leftWrEn), .rightWrEn(rightWrEn)
  );

  arb_control ctl_i (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (leftBusyOutN && rightBusyOutN)); // R9
endmodule

// File: tb/dp_contention_arb_tb.sv
module dp_contention_arb_tb_top;
  localparam int AW = 14;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic leftCeN = 1'b1, rightCeN = 1'b1;
  logic leftRwN = 1'b1, rightRwN = 1'b1;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic leftBusyInN = 1'b1, rightBusyInN = 1'b1;
  logic leftBusyOutN, rightBusyOutN, leftWrEn, rightWrEn;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dp_contention_arb #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftCeN(leftCeN), .leftAddr(leftAddr), .leftRwN(leftRwN),
    .rightCeN(rightCeN), .rightAddr(rightAddr), .rightRwN(rightRwN),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftWrEn(leftWrEn), .rightWrEn(rightWrEn)
  );

  task automatic expect4(string req, logic lb, logic rb, logic lw, logic rw);
    checks++;
    if ({leftBusyOutN, rightBusyOutN, leftWrEn, rightWrEn} !== {lb, rb, lw, rw}) begin
      fails++;
      $display("FAIL %s: lBusy,rBusy,lWr,rWr actual %b%b%b%b expected %b%b%b%b",
               req, leftBusyOutN, rightBusyOutN, leftWrEn, rightWrEn, lb, rb, lw, rw);
    end
  endtask

  // apply after a falling edge, settle, then check before the next rising edge
  task automatic drive(logic lce, logic [AW-1:0] la, logic lrw,
                       logic rce, logic [AW-1:0] ra, logic rrw);
    @(negedge clk);
    leftCeN = lce; leftAddr = la; leftRwN = lrw;
    rightCeN = rce; rightAddr = ra; rightRwN = rrw;
    #1;
  endtask

  task automatic idle();
    drive(1'b1, '0, 1'b1, 1'b1, '0, 1'b1);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    expect4("R9 reset idle", 1, 1, 0, 0);
  endtask

  task automatic t_no_contention();
    leftBusyInN = 1'b0; rightBusyInN = 1'b0;   // ignored in master mode (R6)
    drive(1'b0, 14'd5, 1'b0, 1'b0, 14'd6, 1'b0);
    expect4("R1 differing addr / R6 inputs ignored", 1, 1, 1, 1);
    drive(1'b0, 14'd6, 1'b0, 1'b1, 14'd6, 1'b0);
    expect4("R1 right select high", 1, 1, 1, 0);
    leftBusyInN = 1'b1; rightBusyInN = 1'b1;
    idle();
  endtask

  task automatic t_left_first();
    drive(1'b0, 14'd10, 1'b0, 1'b1, 14'd0, 1'b1);
    expect4("R8 left alone writes", 1, 1, 1, 0);
    drive(1'b0, 14'd10, 1'b0, 1'b0, 14'd10, 1'b0);
    expect4("R2 left first wins / R8 loser write blocked", 1, 0, 1, 0);
    drive(1'b0, 14'd10, 1'b0, 1'b0, 14'd10, 1'b0);
    expect4("R4 left keeps ownership", 1, 0, 1, 0);
    drive(1'b0, 14'd10, 1'b0, 1'b0, 14'd11, 1'b0);
    expect4("R5 mismatch clears busy", 1, 1, 1, 1);
    idle();
  endtask

  task automatic t_right_first_handoff();
    drive(1'b1, 14'd0, 1'b1, 1'b0, 14'd20, 1'b1);
    drive(1'b0, 14'd20, 1'b0, 1'b0, 14'd20, 1'b1);
    expect4("R2 right first wins", 0, 1, 0, 0);
    drive(1'b0, 14'd20, 1'b0, 1'b1, 14'd20, 1'b1);
    expect4("R5 winner select high clears busy", 1, 1, 1, 0);
    drive(1'b0, 14'd20, 1'b0, 1'b0, 14'd20, 1'b0);
    expect4("R5 former loser now earlier wins", 1, 0, 1, 0);
    idle();
  endtask

  task automatic t_tie();
    drive(1'b0, 14'd30, 1'b0, 1'b0, 14'd30, 1'b0);
    expect4("R3 same-cycle tie left wins", 1, 0, 1, 0);
    drive(1'b0, 14'd30, 1'b1, 1'b0, 14'd30, 1'b0);
    expect4("R4 tie winner kept", 1, 0, 0, 0);
    idle();
    drive(1'b0, 14'h3FFF, 1'b0, 1'b0, 14'h3FFF, 1'b0);
    expect4("R3 tie at top address", 1, 0, 1, 0);
    idle();
  endtask

  task automatic t_slave();
    masterMode = 1'b0;
    drive(1'b0, 14'd40, 1'b0, 1'b0, 14'd40, 1'b0);
    expect4("R7 slave busy outputs high", 1, 1, 1, 1);
    leftBusyInN = 1'b0;
    #1;
    expect4("R7 slave left busy input blocks write", 1, 1, 0, 1);
    leftBusyInN = 1'b1; rightBusyInN = 1'b0;
    #1;
    expect4("R7 slave right busy input blocks write", 1, 1, 1, 0);
    rightBusyInN = 1'b1;
    masterMode = 1'b1;
    idle();
  endtask

  initial begin
    t_reset();
    t_no_contention();
    t_left_first();
    t_right_first_handoff();
    t_tie();
    t_slave();
    t_reset();
    drive(1'b0, 14'd50, 1'b0, 1'b0, 14'd50, 1'b0);
    expect4("R9 no history after reset tie", 1, 0, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule